// File: doc/BRIEF.md
# Rate 2/3 (1,7) Run-Length-Limited Write Encoder with Precompensation

The block sits in a disk write path. It accepts user data as a two-bit NRZ word once every three channel clocks and converts it into a (1,7) run-length-limited channel stream at a code rate of 2/3. Every channel bit is then serialised onto one output pin in NRZI form, where a channel 1 toggles the pin. Encoding uses a one-word lookahead: when a word and the word after it would place two channel 1s side by side, both words are replaced by a six-bit substitute.

A five-bit window slides over the serial stream. It marks each transition that sits next to a neighbour two channel bits away on one side only. Such a transition gets an early or late flag, and an external delay stage uses that flag to shift the write edge.

A small configuration register selects the operating mode. Encoding can be bypassed to send raw test bits. Precompensation can be turned off. The output polarity can be inverted. The output can be held flat for DC erase. The whole block can be frozen in power-down.

Top module: `rll17_wr_endec`

## Requirements
- R1: While power-down is clear, `word_take_o` is high on exactly one clock in every three, starting with the first clock after reset, and `data_i` is sampled on each clock edge where it is high.
- R2: Without substitution, a held word maps to three channel bits, sent MSB first: 00 to 101, 01 to 100, 10 to 001, 11 to 010.
- R3: A substitution applies when the held word has bit 0 clear and the next word has bit 1 clear. The two words then become six channel bits: 00,00 to 101000; 00,01 to 100000; 10,00 to 001000; 10,01 to 010000. The second word is consumed, and its three channel bits are 000.
- R4: While encoding is active, no two channel 1s are adjacent and no run of channel 0s between 1s exceeds seven.
- R5: `code_o` toggles for each channel 1 and holds for each channel 0. Channel bit k, counted across the words in order, acts on `code_o` at the clock edge k+7 after the edge that took word 0.
- R6: Configuration bit 2 inverts `code_o`. Before any channel 1 arrives, `code_o` equals this bit.
- R7: Configuration bit 0 bypasses the encoder. Each word d then yields the channel bits {d[1], d[0], 0}, with no lookahead and the same latency as in R5.
- R8: For a channel 1 at position j, `late_o` is high when bit j-2 is 1 and bit j+2 is 0. `early_o` is high when bit j-2 is 0 and bit j+2 is 1. Both flags are aligned with the `code_o` edge of bit j, and bits before the stream count as 0.
- R9: Configuration bit 1 forces `early_o` and `late_o` low from the next edge.
- R10: Configuration bit 3 (DC erase) holds `code_o` at the level of bit 2 with no transitions and keeps both flags low.
- R11: Configuration bit 4 (power-down) stops all activity: `word_take_o` is low and `code_o`, `early_o` and `late_o` hold. Clearing the bit resumes the three-clock cadence.
- R12: During reset the configuration is zero and `code_o`, `early_o` and `late_o` are low.
- R13: The configuration register is loaded from `cfg_wdata_i` on a clock edge where `cfg_we_i` is high, and its effect appears from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | Configuration value: bit0 bypass, bit1 precomp off, bit2 invert, bit3 DC erase, bit4 power-down |
| data_i | input | 2 | NRZ data word |
| word_take_o | output | 1 | Marks the edge on which `data_i` is sampled |
| code_o | output | 1 | Serial NRZI code output |
| early_o | output | 1 | Write this transition early |
| late_o | output | 1 | Write this transition late |

## Verification
The inline assertions check the following on every cycle:
- a take is never followed by another take on the next cycle;
- no loaded triplet holds adjacent 1s while encoding;
- the precompensation flags rise only on a cycle where `code_o` toggles;
- precomp-off and erase silence the flags, and erase flattens the output;
- power-down freezes the serialiser and the outputs.

Only the bench's scenarios can show the rest:
- that the table and lookahead substitution produce the right stream, and that it decodes back to the input words;
- the exact seven-clock latency;
- that the early/late choice matches the neighbours two bits away;
- that bypass, inversion and resume after power-down behave end to end.

// File: rtl/rll17_pkg.sv
package rll17_pkg;
  localparam int unsigned DATA_W = 2;
  localparam int unsigned SYM_W  = 3;

  typedef struct packed {
    logic pdown;
    logic dc_erase;
    logic inv;
    logic pc_off;
    logic enc_bypass;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  function automatic logic [SYM_W-1:0] map_direct(input logic [DATA_W-1:0] p);
    case (p)
      2'b00:   return 3'b101;
      2'b01:   return 3'b100;
      2'b10:   return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  // leading triplet of a substituted pair; trailing triplet is all zero
  function automatic logic [SYM_W-1:0] map_sub(input logic [2*DATA_W-1:0] pn);
    case (pn)
      4'b0000: return 3'b101;
      4'b0001: return 3'b100;
      4'b1000: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic needs_sub(input logic p_lsb, input logic n_msb);
    return !p_lsb && !n_msb;
  endfunction
endpackage

// File: rtl/rll17_encoder.sv
module rll17_encoder import rll17_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              bypass_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SYM_W-1:0]  sym_o
);
  logic [DATA_W-1:0] hold_q;
  logic              valid_q;
  logic              pend_q;
  logic              sub_now;

  always_comb begin
    sub_now = 1'b0;
    if (!valid_q) begin
      sym_o = '0;
    end else if (bypass_i) begin
      sym_o = {hold_q, {(SYM_W-DATA_W){1'b0}}};
    end else if (pend_q) begin
      sym_o = '0;
    end else if (needs_sub(hold_q[0], data_i[DATA_W-1])) begin
      sym_o   = map_sub({hold_q, data_i});
      sub_now = 1'b1;
    end else begin
      sym_o = map_direct(hold_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (adv_i) begin
      hold_q  <= data_i;
      valid_q <= 1'b1;
      pend_q  <= sub_now;
    end
  end

  // R4: every triplet loaded while encoding keeps 1s apart
  a_r4_sym_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !bypass_i |-> !(sym_o[2] && sym_o[1]) && !(sym_o[1] && sym_o[0]));
endmodule

// File: rtl/rll17_serializer.sv
module rll17_serializer #(
  parameter int unsigned SYM_W   = 3,
  parameter int unsigned PC_SPAN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             slot_o,
  output logic             bit_before_o,
  output logic             bit_now_o,
  output logic             bit_after_o
);
  localparam int unsigned WIN_W = 2*PC_SPAN + 1;
  localparam int unsigned PH_W  = $clog2(SYM_W);

  logic [PH_W-1:0]  ph_q;
  logic [SYM_W-1:0] sh_q;
  logic [WIN_W-1:0] win_q;   // bit 0 newest

  assign slot_o = (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      sh_q  <= '0;
      win_q <= '0;
    end else if (run_i) begin
      ph_q  <= (ph_q == PH_W'(SYM_W-1)) ? '0 : ph_q + 1'b1;
      sh_q  <= slot_o ? sym_i : (sh_q << 1);
      win_q <= {win_q[WIN_W-2:0], sh_q[SYM_W-1]};
    end
  end

  assign bit_after_o  = win_q[0];
  assign bit_now_o    = win_q[PC_SPAN];
  assign bit_before_o = win_q[WIN_W-1];

  // R11: nothing moves while powered down
  a_r11_ser_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(sh_q) && $stable(win_q) && $stable(ph_q));
endmodule

// File: rtl/rll17_precomp.sv
module rll17_precomp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pc_off_i,
  input  logic erase_i,
  input  logic inv_i,
  input  logic bit_before_i,
  input  logic bit_now_i,
  input  logic bit_after_i,
  output logic code_o,
  output logic early_o,
  output logic late_o
);
  logic code_q, early_q, late_q;
  logic flag_en;

  assign flag_en = !pc_off_i && !erase_i && bit_now_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= 1'b0;
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else if (run_i) begin
      code_q  <= erase_i ? 1'b0 : (code_q ^ bit_now_i);
      early_q <= flag_en && !bit_before_i && bit_after_i;
      late_q  <= flag_en && bit_before_i && !bit_after_i;
    end
  end

  assign code_o  = code_q ^ inv_i;
  assign early_o = early_q;
  assign late_o  = late_q;

  // R8: a flag only accompanies a written transition
  a_r8_flag_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_q || late_q) |-> code_q != $past(code_q));
  a_r9_pc_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_off_i && run_i |=> !early_q && !late_q);
  a_r10_erase_flat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i && run_i |=> !code_q && !early_q && !late_q);
  a_r11_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(code_q) && $stable(early_q) && $stable(late_q));
endmodule

// File: rtl/rll17_wr_endec.sv
module rll17_wr_endec import rll17_pkg::*; #(
  parameter int unsigned PC_SPAN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              word_take_o,
  output logic              code_o,
  output logic              early_o,
  output logic              late_o
);
  cfg_t             cfg_q;
  logic [SYM_W-1:0] sym;
  logic             slot, run;
  logic             b_before, b_now, b_after;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign run         = !cfg_q.pdown;
  assign word_take_o = slot && run;

  rll17_encoder u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (word_take_o),
    .bypass_i (cfg_q.enc_bypass),
    .data_i   (data_i),
    .sym_o    (sym)
  );

  rll17_serializer #(.SYM_W(SYM_W), .PC_SPAN(PC_SPAN)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .sym_i        (sym),
    .slot_o       (slot),
    .bit_before_o (b_before),
    .bit_now_o    (b_now),
    .bit_after_o  (b_after)
  );

  rll17_precomp u_pc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .pc_off_i     (cfg_q.pc_off),
    .erase_i      (cfg_q.dc_erase),
    .inv_i        (cfg_q.inv),
    .bit_before_i (b_before),
    .bit_now_i    (b_now),
    .bit_after_i  (b_after),
    .code_o       (code_o),
    .early_o      (early_o),
    .late_o       (late_o)
  );

  // R1: takes never come back to back
  a_r1_take_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_take_o |=> !word_take_o);
endmodule

// File: tb/rll17_wr_endec_tb_top.sv
module rll17_wr_endec_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = 5'b0;
  logic [1:0] data_i = 2'b0;
  logic       word_take_o, code_o, early_o, late_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  rll17_wr_endec dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .data_i(data_i), .word_take_o(word_take_o), .code_o(code_o),
    .early_o(early_o), .late_o(late_o)
  );

  always #10 clk_i = ~clk_i;

  logic [1:0] words[$];
  bit         exp_q[$];
  bit         hist[$];
  bit         hist_e[$];
  bit         hist_l[$];
  logic [4:0] mode;
  bit         pend_m;
  int         lfsr;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_direct(input logic [1:0] p);
    case (p)
      2'b00: return 3'b101;
      2'b01: return 3'b100;
      2'b10: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [2:0] ref_sub(input logic [1:0] p, input logic [1:0] n);
    if (p == 2'b00) return (n == 2'b00) ? 3'b101 : 3'b100;
    return (n == 2'b00) ? 3'b001 : 3'b010;
  endfunction

  task automatic push3(input logic [2:0] s);
    exp_q.push_back(s[2]);
    exp_q.push_back(s[1]);
    exp_q.push_back(s[0]);
  endtask

  // driver-side model: emits the triplet of prev once nxt is known
  task automatic model_step(input logic [1:0] prev, input logic [1:0] nxt);
    if (mode[0]) push3({prev, 1'b0});
    else if (pend_m) begin push3(3'b000); pend_m = 1'b0; end
    else if (!prev[0] && !nxt[1]) begin push3(ref_sub(prev, nxt)); pend_m = 1'b1; end
    else push3(ref_direct(prev));
  endtask

  function automatic logic [2:0] trip(input int t);
    return {hist[3*t], hist[3*t+1], hist[3*t+2]};
  endfunction

  task automatic build_words(input int nw, input int seed, input bit directed);
    logic [1:0] pre[12] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1, 2'd3, 2'd3, 2'd1, 2'd2};
    words.delete();
    lfsr = seed;
    if (directed) for (int i = 0; i < 12; i++) words.push_back(pre[i]);
    while (words.size() < nw) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >>> 17);
      lfsr = lfsr ^ (lfsr << 5);
      words.push_back(lfsr[5:4]);
    end
    for (int i = 0; i < 3; i++) words.push_back(2'b00);
  endtask

  task automatic post_checks(input int nw, input bit directed);
    int adj, maxrun, run, seen1, mism, subs, t;
    logic [2:0] tr, tn;
    logic [1:0] p0, p1;
    adj = 0; maxrun = 0; run = 0; seen1 = 0;
    for (int i = 0; i < 3*nw; i++) begin
      if (hist[i]) begin
        if (i > 0 && hist[i-1]) adj++;
        if (seen1 != 0 && run > maxrun) maxrun = run;
        seen1 = 1; run = 0;
      end else run++;
    end
    check(adj == 0, "R4", "adjacent channel 1s", adj, 0);
    check(maxrun <= 7, "R4", "longest zero run", maxrun, 7);
    mism = 0; subs = 0; t = 0;
    while (t < nw) begin
      tr = trip(t); tn = trip(t+1);
      if (tn == 3'b000) begin
        case (tr)
          3'b101: begin p0 = 2'd0; p1 = 2'd0; end
          3'b100: begin p0 = 2'd0; p1 = 2'd1; end
          3'b001: begin p0 = 2'd2; p1 = 2'd0; end
          3'b010: begin p0 = 2'd2; p1 = 2'd1; end
          default: begin p0 = 2'bxx; p1 = 2'bxx; mism++; end
        endcase
        if (p0 !== words[t]) mism++;
        if (t+1 < nw && p1 !== words[t+1]) mism++;
        subs++; t += 2;
      end else begin
        case (tr)
          3'b101: p0 = 2'd0;
          3'b100: p0 = 2'd1;
          3'b001: p0 = 2'd2;
          3'b010: p0 = 2'd3;
          default: begin p0 = 2'bxx; mism++; end
        endcase
        if (p0 !== words[t]) mism++;
        t++;
      end
    end
    check(mism == 0, "R2", "decoded word mismatches", mism, 0);
    if (directed) check(subs >= 4, "R3", "substitutions decoded", subs, 4);
  endtask

  task automatic run_stream(input logic [4:0] m, input int nw, input int seed, input bit directed);
    int nbits, done_bits, e, takes, k, j;
    bit prev_code, cur, bt, expb, bb, exp_e, exp_l;
    mode = m; pend_m = 1'b0;
    build_words(nw, seed, directed);
    exp_q.delete(); hist.delete(); hist_e.delete(); hist_l.delete();
    @(negedge clk_i);
    rst_ni = 1'b0; cfg_we_i = 1'b1; cfg_wdata_i = m; data_i = words[0];
    repeat (2) @(negedge clk_i);
    check(code_o == 1'b0 && !early_o && !late_o, "R12", "outputs in reset",
          int'({code_o, early_o, late_o}), 0);
    rst_ni = 1'b1;
    check(word_take_o == 1'b1, "R1", "take on first clock", int'(word_take_o), 1);
    nbits = 3*(nw+1);
    fork
      begin
        for (int i = 0; i < words.size(); i++) begin
          if (i > 0) begin
            data_i = words[i];
            model_step(words[i-1], words[i]);
          end
          while (!word_take_o) @(negedge clk_i);
          @(negedge clk_i);
          cfg_we_i = 1'b0;
        end
        data_i = 2'b00;
      end
      begin
        prev_code = code_o; takes = 0; done_bits = 0; e = 0;
        while (done_bits < nbits) begin
          @(negedge clk_i);
          cur = code_o; bt = cur ^ prev_code; prev_code = cur;
          if (e < 30 && word_take_o) takes++;
          if (e == 30) check(takes == 10, "R1", "takes in 30 clocks", takes, 10);
          if (e < 7) begin
            check(code_o == m[2], "R6", "level before first bit", int'(code_o), int'(m[2]));
          end else if (m[3]) begin
            check(code_o == m[2] && !early_o && !late_o, "R10", "erase output",
                  int'({code_o, early_o, late_o}), int'({m[2], 2'b00}));
            done_bits++;
          end else begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R5", "model underrun", 0, 1);
              expb = 1'b0;
            end else expb = exp_q.pop_front();
            check(bt == expb, m[0] ? "R7" : "R5", $sformatf("channel bit %0d", done_bits),
                  int'(bt), int'(expb));
            hist.push_back(bt); hist_e.push_back(early_o); hist_l.push_back(late_o);
            k = hist.size() - 1; j = k - 2;
            if (j >= 0) begin
              bb = (j >= 2) ? hist[j-2] : 1'b0;
              exp_e = !m[1] && hist[j] && !bb && hist[k];
              exp_l = !m[1] && hist[j] && bb && !hist[k];
              check(hist_e[j] == exp_e && hist_l[j] == exp_l, m[1] ? "R9" : "R8",
                    $sformatf("early/late at bit %0d", j),
                    int'({hist_e[j], hist_l[j]}), int'({exp_e, exp_l}));
            end
            done_bits++;
          end
          e++;
        end
      end
    join
    if (!m[3] && !m[0]) post_checks(nw, directed);
  endtask

  task automatic pdown_test();
    bit sc, se, sl;
    int tk;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 5'b10000;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    check(!word_take_o, "R13", "power-down bit applied next edge", int'(word_take_o), 0);
    sc = code_o; se = early_o; sl = late_o;
    repeat (12) begin
      @(negedge clk_i);
      check(!word_take_o && code_o == sc && early_o == se && late_o == sl, "R11", "frozen outputs",
            int'({word_take_o, code_o, early_o, late_o}), int'({1'b0, sc, se, sl}));
    end
    cfg_we_i = 1'b1; cfg_wdata_i = 5'b00000;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    tk = 0;
    repeat (6) begin
      if (word_take_o) tk++;
      @(negedge clk_i);
    end
    check(tk == 2, "R11", "takes after resume in 6 clocks", tk, 2);
  endtask

  initial begin
    run_stream(5'b00000, 120, 32'h1357, 1'b1);
    run_stream(5'b00100, 60, 32'h2468, 1'b0);
    run_stream(5'b00001, 40, 32'h0bad, 1'b0);
    run_stream(5'b00010, 60, 32'h7777, 1'b1);
    run_stream(5'b01100, 20, 32'h4321, 1'b0);
    run_stream(5'b00000, 30, 32'h9abc, 1'b0);
    pdown_test();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule